// File: doc/BRIEF.md
# Halt-Aware PWM Timer with Output Compare

This block is an up-counting timer that drives a set of channel pins. Each channel is either an edge-aligned PWM generator or an output-compare toggler. A single register write port loads the start value, the end value, the per-channel compare values, the channel kinds and the per-channel initial output levels. The same port issues three strobes: a counter restart, an output initialisation, and a flag clear. A one-cycle synchronization-reset input also restarts the counter.

A debug-halt input and a 2-bit halt policy decide what happens while the chip is halted. In the run policy the timer behaves as if no halt were present. The other three policies freeze the counter and the compare logic. One of them also shows the initial levels on the pins. While the timer is frozen, a counter restart, a synchronization reset or an initialisation strobe still moves the outputs. On resume, a PWM channel whose compare value equals the start value raises its flag on the first count.

Top module: `dbg_pwm_timer`

## Requirements
- R1: After reset the count reads 0, and all channel pins and all flags are 0.
- R2: Writes select a register by address: 1 start value, 2 end value, 3 channel kind (bit n = 1 makes channel n output-compare, 0 makes it PWM), 4 initial levels (bit n for channel n), 8+n compare value of channel n. When running, the count advances by one per clock from the start value and returns to the start value on the clock after it equals the end value.
- R3: A PWM channel pin goes to 1 one clock after the count evaluated equals the start value, and goes to 0 one clock after the count equals its compare value. A compare match takes priority, so a compare value equal to the start value keeps the pin low. A match sets the channel flag.
- R4: An output-compare channel inverts its pin and sets its flag one clock after the count equals its compare value. A write to address 6 clears flag n where data bit n is 0 and leaves it where data bit n is 1.
- R5: With halt active and policy 2'b11, the count keeps advancing and flags keep being set.
- R6: With halt active and policy 2'b00 or 2'b10, the count, the pins and the flags do not change unless a restart, a synchronization reset or an initialisation strobe occurs.
- R7: With halt active and policy 2'b01, the count is frozen and the pins show the initial levels. Moving to a holding policy shows the held levels again at once.
- R8: A write to address 0, with any data and in any state including halt, loads the count with the start value on that clock. Every PWM pin takes its initial level, and output-compare pins are untouched.
- R9: A one-clock pulse on the synchronization reset has the same effect as R8, including while halted.
- R10: A write to address 5 with data bit 0 set loads every pin, output-compare included, with its initial level, including while halted.
- R11: If halt ends with the count at the start value and a PWM compare value equal to the start value, that channel flag is set on the first clock after halt ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | CNT_W | Write data |
| sync_rst | input | 1 | Synchronization reset pulse, restarts the counter |
| dbg_halt | input | 1 | Chip is in debug halt |
| dbg_mode | input | 2 | Halt policy |
| ch_pin | output | NCH | Channel output pins |
| ch_flag | output | NCH | Channel event flags |
| cnt_val | output | CNT_W | Current count |

## Verification
Seven timer settings are run from a restart with channel 0 in PWM. They cover a wrapping period, a compare value past the end value (always high), a compare value equal to the start value (always low), and a compare value equal to the end value. Together they separate off-by-one errors in the wrap, in the match priority and in the output register delay. Directed sequences then walk through every halt policy. Restart, synchronization reset and initialisation are each applied while frozen, with initial levels chosen so that a channel of the wrong kind would land on a different value. A final sequence resumes from the start value to catch a missing 0% flag.

// File: rtl/dpt_pkg.sv
// Shared definitions for the halt-aware PWM timer.
// Assumes a 4-bit register address and at most 8 channels.
package dpt_pkg;
    typedef enum logic [1:0] {
        DBG_FREEZE_HOLD = 2'b00,
        DBG_FREEZE_SAFE = 2'b01,
        DBG_FREEZE_KEEP = 2'b10,
        DBG_RUN         = 2'b11
    } dbg_mode_e;

    localparam int unsigned ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_RESTART  = 4'd0;
    localparam logic [ADDR_W-1:0] A_START    = 4'd1;
    localparam logic [ADDR_W-1:0] A_END      = 4'd2;
    localparam logic [ADDR_W-1:0] A_KIND     = 4'd3;
    localparam logic [ADDR_W-1:0] A_INITLVL  = 4'd4;
    localparam logic [ADDR_W-1:0] A_INITSTB  = 4'd5;
    localparam logic [ADDR_W-1:0] A_FLAGWR   = 4'd6;
    localparam logic [ADDR_W-1:0] A_CMP_BASE = 4'd8;
endpackage

// File: rtl/dpt_regs.sv
// Register file and strobe decode for the timer.
// Holds the start, end and compare values, the channel kinds and the initial
// levels. Restart, init and flag-write strobes are decoded combinationally
// so that they act on the same clock edge that samples the write.
// Assumes CNT_W >= NCH and NCH <= 8.
module dpt_regs
    import dpt_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned NCH   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [CNT_W-1:0]    wr_data,
    output logic [CNT_W-1:0]    start_q,
    output logic [CNT_W-1:0]    end_q,
    output logic [CNT_W-1:0]    cmp_q [NCH],
    output logic [NCH-1:0]      kind_oc_q,
    output logic [NCH-1:0]      init_lvl_q,
    output logic                restart_stb,
    output logic                init_stb,
    output logic                flag_wr,
    output logic [NCH-1:0]      flag_keep
);
    // Strobe decode: one-cycle actions taken at the write edge.
    always_comb begin
        restart_stb = wr_en && (wr_addr == A_RESTART);
        init_stb    = wr_en && (wr_addr == A_INITSTB) && wr_data[0];
        flag_wr     = wr_en && (wr_addr == A_FLAGWR);
        flag_keep   = wr_data[NCH-1:0];
    end

    // Shared configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q    <= '0;
            end_q      <= '1;
            kind_oc_q  <= '0;
            init_lvl_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_START)   start_q    <= wr_data;
            if (wr_addr == A_END)     end_q      <= wr_data;
            if (wr_addr == A_KIND)    kind_oc_q  <= wr_data[NCH-1:0];
            if (wr_addr == A_INITLVL) init_lvl_q <= wr_data[NCH-1:0];
        end
    end

    // Per-channel compare value registers.
    for (genvar n = 0; n < NCH; n++) begin : g_cmp
        localparam logic [ADDR_W-1:0] MY_ADDR = A_CMP_BASE + ADDR_W'(n);
        always_ff @(posedge clk) begin
            if (!rst_n)                             cmp_q[n] <= '0;
            else if (wr_en && (wr_addr == MY_ADDR)) cmp_q[n] <= wr_data;
        end
    end
endmodule

// File: rtl/dpt_counter.sv
// Up-counter with halt gating.
// Counts from the start value to the end value and wraps. It is frozen in any
// halt policy other than run. A restart or sync reset reloads the start value
// in every state. run_o marks the cycles in which the current count is
// evaluated by the channels. Each count value is evaluated exactly once.
module dpt_counter
    import dpt_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt,
    input  logic [1:0]       mode,
    input  logic             restart_stb,
    input  logic             sync_rst,
    input  logic [CNT_W-1:0] start_val,
    input  logic [CNT_W-1:0] end_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             run_o,
    output logic             reload_o
);
    logic frozen;

    // Decide whether this cycle reloads, counts or holds.
    always_comb begin
        frozen   = halt && (mode != DBG_RUN);
        reload_o = restart_stb || sync_rst;
        run_o    = !frozen && !reload_o;
    end

    // Count register: reload wins, then advance with wrap, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (reload_o) cnt_q <= start_val;
        else if (run_o)    cnt_q <= (cnt_q == end_val) ? start_val : cnt_q + 1'b1;
    end

    p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !reload_o) |=> (cnt_q == $past(cnt_q)));
    p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reload_o |=> (cnt_q == $past(start_val)));
    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && (cnt_q == end_val)) |=> (cnt_q == $past(start_val)));
endmodule

// File: rtl/dpt_channel.sv
// One timer channel: edge-aligned PWM or output compare.
// The output register is loaded by init (all kinds), by a counter reload
// (PWM kind only), or by compare logic in run cycles. The flag is set on a
// compare match in run cycles. A flag write with a 0 in the keep bit clears it.
// A set on the same edge wins over a clear.
module dpt_channel #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             reload,
    input  logic             init_stb,
    input  logic             kind_oc,
    input  logic             init_lvl,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] start_val,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             flag_wr,
    input  logic             flag_keep,
    output logic             out_q,
    output logic             flag_q
);
    logic hit;

    // Compare match of the count under evaluation.
    always_comb hit = (cnt == cmp_val);

    // Output register: init, then PWM reload, then compare behaviour.
    always_ff @(posedge clk) begin
        if (!rst_n)                  out_q <= 1'b0;
        else if (init_stb)           out_q <= init_lvl;
        else if (reload && !kind_oc) out_q <= init_lvl;
        else if (run) begin
            if (kind_oc) begin
                if (hit) out_q <= !out_q;
            end else if (hit) begin
                out_q <= 1'b0;
            end else if (cnt == start_val) begin
                out_q <= 1'b1;
            end
        end
    end

    // Event flag: set on match, cleared by a zero write.
    always_ff @(posedge clk) begin
        if (!rst_n)                     flag_q <= 1'b0;
        else if (run && hit)            flag_q <= 1'b1;
        else if (flag_wr && !flag_keep) flag_q <= 1'b0;
    end

    p_init_r10: assert property (@(posedge clk) disable iff (!rst_n)
        init_stb |=> (out_q == $past(init_lvl)));
    p_oc_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && kind_oc && !init_stb) |=> $stable(out_q));
    p_no_flag_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !$rose(flag_q));
    p_oc_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && kind_oc && hit && !init_stb) |=> (out_q != $past(out_q)));
endmodule

// File: rtl/dbg_pwm_timer.sv
// Top of the halt-aware PWM timer.
// Ties the register file, the counter and NCH channels together. In the
// safe halt policy the pins show the initial levels while the channel
// registers keep their held state.
module dbg_pwm_timer
    import dpt_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned NCH   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [3:0]         wr_addr,
    input  logic [CNT_W-1:0]   wr_data,
    input  logic               sync_rst,
    input  logic               dbg_halt,
    input  logic [1:0]         dbg_mode,
    output logic [NCH-1:0]     ch_pin,
    output logic [NCH-1:0]     ch_flag,
    output logic [CNT_W-1:0]   cnt_val
);
    logic [CNT_W-1:0] start_q, end_q;
    logic [CNT_W-1:0] cmp_q [NCH];
    logic [NCH-1:0]   kind_oc_q, init_lvl_q, flag_keep, out_q;
    logic             restart_stb, init_stb, flag_wr, run, reload, safe_show;

    dpt_regs #(.CNT_W(CNT_W), .NCH(NCH)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .start_q(start_q), .end_q(end_q), .cmp_q(cmp_q),
        .kind_oc_q(kind_oc_q), .init_lvl_q(init_lvl_q),
        .restart_stb(restart_stb), .init_stb(init_stb),
        .flag_wr(flag_wr), .flag_keep(flag_keep)
    );

    dpt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .halt(dbg_halt), .mode(dbg_mode),
        .restart_stb(restart_stb), .sync_rst(sync_rst),
        .start_val(start_q), .end_val(end_q),
        .cnt_q(cnt_val), .run_o(run), .reload_o(reload)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        dpt_channel #(.CNT_W(CNT_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .run(run), .reload(reload),
            .init_stb(init_stb), .kind_oc(kind_oc_q[n]),
            .init_lvl(init_lvl_q[n]), .cnt(cnt_val), .start_val(start_q),
            .cmp_val(cmp_q[n]), .flag_wr(flag_wr), .flag_keep(flag_keep[n]),
            .out_q(out_q[n]), .flag_q(ch_flag[n])
        );
    end

    // Pin select: initial levels in the safe halt policy, held state otherwise.
    always_comb begin
        safe_show = dbg_halt && (dbg_mode == DBG_FREEZE_SAFE);
        ch_pin    = safe_show ? init_lvl_q : out_q;
    end

    p_pins_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_halt && dbg_mode == DBG_FREEZE_HOLD && !reload && !init_stb)
        |=> (out_q == $past(out_q)));
endmodule

// File: tb/dbg_pwm_timer_bench.sv
module dbg_pwm_timer_bench;
    localparam int CW = 16;
    localparam int NC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic          sync_rst = 1'b0;
    logic          dbg_halt = 1'b0;
    logic [1:0]    dbg_mode = 2'b00;
    logic [NC-1:0] ch_pin, ch_flag;
    logic [CW-1:0] cnt_val;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = !clk;

    dbg_pwm_timer #(.CNT_W(CW), .NCH(NC)) u_dbg_pwm_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sync_rst(sync_rst), .dbg_halt(dbg_halt),
        .dbg_mode(dbg_mode), .ch_pin(ch_pin), .ch_flag(ch_flag),
        .cnt_val(cnt_val)
    );

    typedef struct packed {
        logic [15:0] start;
        logic [15:0] stop;
        logic [15:0] cmp;
        logic [15:0] steps;
        logic [15:0] exp_cnt;
        logic        exp_pin;
        logic        exp_flag;
    } vec_t;

    // Channel 0 PWM runs from a restart; expected values follow R2 and R3.
    localparam vec_t VEC [0:6] = '{
        '{16'd0, 16'd9,  16'd4, 16'd3,  16'd3, 1'b1, 1'b0},
        '{16'd0, 16'd9,  16'd4, 16'd6,  16'd6, 1'b0, 1'b1},
        '{16'd0, 16'd9,  16'd4, 16'd11, 16'd1, 1'b1, 1'b1},
        '{16'd5, 16'd12, 16'd5, 16'd4,  16'd9, 1'b0, 1'b1},
        '{16'd2, 16'd7,  16'd8, 16'd9,  16'd5, 1'b1, 1'b0},
        '{16'd3, 16'd6,  16'd6, 16'd4,  16'd3, 1'b0, 1'b1},
        '{16'd0, 16'd3,  16'd2, 16'd2,  16'd2, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [CW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [CW-1:0] c;
        logic [NC-1:0] p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 count", 32'(cnt_val), 0);
        chk("R1 pins", 32'(ch_pin), 0);
        chk("R1 flags", 32'(ch_flag), 0);

        // Table walk: set up frozen, restart, resume, count steps.
        for (int i = 0; i <= 6; i++) begin
            dbg_halt = 1'b1; dbg_mode = 2'b00;
            wr(4'd1, VEC[i].start);
            wr(4'd2, VEC[i].stop);
            wr(4'd8, VEC[i].cmp);
            wr(4'd3, 16'h0);
            wr(4'd4, 16'h0);
            wr(4'd5, 16'h1);
            wr(4'd0, 16'h0);
            wr(4'd6, 16'h0);
            dbg_halt = 1'b0;
            tick(int'(VEC[i].steps));
            chk($sformatf("R2 vec%0d count", i), 32'(cnt_val), 32'(VEC[i].exp_cnt));
            chk($sformatf("R3 vec%0d pin", i), 32'(ch_pin[0]), 32'(VEC[i].exp_pin));
            chk($sformatf("R3 vec%0d flag", i), 32'(ch_flag[0]), 32'(VEC[i].exp_flag));
        end

        // R4: channel 1 output compare at 3, range 0..9.
        dbg_halt = 1'b1; dbg_mode = 2'b00;
        wr(4'd1, 16'd0); wr(4'd2, 16'd9); wr(4'd9, 16'd3);
        wr(4'd3, 16'h2); wr(4'd4, 16'h0); wr(4'd5, 16'h1);
        wr(4'd0, 16'h0); wr(4'd6, 16'h0);
        dbg_halt = 1'b0;
        tick(3);
        chk("R4 before match", 32'(ch_pin[1]), 0);
        tick(1);
        chk("R4 toggled", 32'(ch_pin[1]), 1);
        chk("R4 flag set", 32'(ch_flag[1]), 1);
        wr(4'd6, 16'hD);
        chk("R4 flag cleared", 32'(ch_flag[1]), 0);

        // R5: run policy while halted.
        dbg_halt = 1'b1; dbg_mode = 2'b11;
        c = cnt_val;
        tick(3);
        for (int k = 0; k < 3; k++) c = (c == 16'd9) ? 16'd0 : c + 1'b1;
        chk("R5 counting in halt", 32'(cnt_val), 32'(c));
        wr(4'd6, 16'h0);
        tick(10);
        chk("R5 flag in halt", 32'(ch_flag[1]), 1);

        // R6: hold policies freeze everything.
        dbg_mode = 2'b00;
        c = cnt_val; p = ch_pin;
        wr(4'd6, 16'h0);
        tick(5);
        chk("R6 hold count", 32'(cnt_val), 32'(c));
        chk("R6 hold pins", 32'(ch_pin), 32'(p));
        chk("R6 no flags", 32'(ch_flag), 0);
        dbg_mode = 2'b10;
        tick(4);
        chk("R6 keep count", 32'(cnt_val), 32'(c));
        chk("R6 keep pins", 32'(ch_pin), 32'(p));

        // R7: safe policy shows initial levels.
        wr(4'd4, 16'hA);
        dbg_mode = 2'b01;
        #1;
        chk("R7 safe pins", 32'(ch_pin), 32'hA);
        tick(3);
        chk("R7 safe count", 32'(cnt_val), 32'(c));
        dbg_mode = 2'b00;
        #1;
        chk("R7 held pins back", 32'(ch_pin), 32'(p));

        // R8: restart while frozen, OC channel 1 untouched.
        wr(4'd4, 16'h0); wr(4'd5, 16'h1);
        wr(4'd1, 16'd2); wr(4'd4, 16'hF); wr(4'd0, 16'h1234);
        chk("R8 count", 32'(cnt_val), 2);
        chk("R8 pins", 32'(ch_pin), 32'hD);

        // R9: sync reset while frozen.
        wr(4'd1, 16'd6); wr(4'd4, 16'h2);
        @(negedge clk); sync_rst = 1'b1;
        @(negedge clk); sync_rst = 1'b0;
        chk("R9 count", 32'(cnt_val), 6);
        chk("R9 pins", 32'(ch_pin), 0);

        // R10: init strobe while frozen, OC included.
        wr(4'd4, 16'h6); wr(4'd5, 16'h1);
        chk("R10 pins", 32'(ch_pin), 32'h6);
        chk("R10 count", 32'(cnt_val), 6);

        // R11: 0% channel flag on resume.
        wr(4'd2, 16'd9); wr(4'd8, 16'd6); wr(4'd0, 16'h0); wr(4'd6, 16'h0);
        tick(3);
        chk("R11 no flag while frozen", 32'(ch_flag[0]), 0);
        dbg_halt = 1'b0;
        tick(1);
        chk("R11 flag on resume", 32'(ch_flag[0]), 1);
        chk("R11 pin low", 32'(ch_pin[0]), 0);
        chk("R11 count moved", 32'(cnt_val), 7);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule